// File: doc/BRIEF.md
# Floating-Point to Signed 32-bit Integer Converter

This block takes a floating-point operand that has already been unpacked into a class tag, a sign, a signed unbiased exponent and a 56-bit significand, and produces a saturating two's-complement 32-bit integer. The significand carries its leading one at bit 55. A 2-bit rounding-mode input selects how the discarded fraction is treated. Operands whose magnitude is below one take a separate path that needs no shifting. Large exponents, infinities and NaNs saturate to the extreme value of the operand's sign.

Conversions arrive on a valid/ready handshake, one per beat. Each accepted beat produces a result one cycle later in a single output register. That register holds its value while the consumer stalls.

Top module: `fpToIntTop`

## Requirements
- R1: An operand of class zero (inClass = 1) gives result 0, whatever the sign, exponent and significand.
- R2: An operand of class NaN (inClass = 2) or infinity (inClass = 3) gives 0x80000000 when inSign is 1 and 0x7FFFFFFF when inSign is 0.
- R3: A normal operand (inClass = 0) whose exponent, read as a 12-bit two's-complement value, is 31 or more gives the same sign-dependent saturation values as R2.
- R4: In nearest mode (inMode = 0), a normal operand with exponent -1 gives +1 (sign 0) or -1 (sign 1), and one with exponent -2 or lower gives 0.
- R5: For a normal operand with a negative exponent, toward-zero mode (inMode = 1) gives 0, toward-plus-infinity (inMode = 2) gives 1 for sign 0 and 0 for sign 1, and toward-minus-infinity (inMode = 3) gives -1 for sign 1 and 0 for sign 0.
- R6: For a normal operand with exponent e in 0..30, the magnitude before rounding is the significand shifted right by 55 - e, and toward-zero mode never adds to it.
- R7: In nearest mode, the magnitude is incremented by one exactly when the highest discarded bit is set, so exact halves round away from zero.
- R8: In the directed modes the magnitude is incremented by one exactly when some discarded bit is set and the direction matches the sign (plus infinity with sign 0, minus infinity with sign 1).
- R9: If bit 31 of the incremented magnitude is set, the result saturates by sign as in R2; otherwise it is the magnitude, negated in two's complement when the sign is 1.
- R10: A beat is accepted when inValid and inReady are both high. inReady is high when outValid is low or outReady is high. The result appears with outValid one cycle after acceptance. It stays unchanged while outValid is high and outReady is low.
- R11: While rstN is low, outValid is 0 and outResult is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset |
| inValid | input | 1 | Operand beat valid |
| inReady | output | 1 | Block can take a beat |
| inClass | input | 2 | 0 normal, 1 zero, 2 NaN, 3 infinity |
| inSign | input | 1 | Operand sign, 1 = negative |
| inExp | input | 12 | Unbiased exponent, two's complement |
| inMant | input | 56 | Significand, leading one at bit 55 |
| inMode | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Consumer takes the result |
| outResult | output | 32 | Signed integer result |

## Verification
A bad path select in the control would send an operand through the wrong arm. The result would then be a saturation value, 0 or ±1 where a shifted magnitude was due, and this shows on outResult in the cycle after acceptance. A wrong shift amount or discard mask gives an off-by-one or a power-of-two error, and only operands with the right exponent and discarded bits reveal it. For that reason the random operands sweep every exponent from -3 to 33 and sometimes zero the low bits to form exact integers and halves. A wrong handshake state shows as a changed result or a raised inReady during a stall.

// File: rtl/fpToIntPkg.sv
package fpToIntPkg;

  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_NAN  = 2'd2,
    CLS_INF  = 2'd3
  } opClass_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_PINF = 2'd2,
    RM_MINF = 2'd3
  } roundMode_e;

  typedef enum logic [1:0] {
    PATH_ZERO  = 2'd0,
    PATH_SAT   = 2'd1,
    PATH_FRAC  = 2'd2,
    PATH_SHIFT = 2'd3
  } pathSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;      // capture a new result
    pathSel_e path;      // which arm forms the result
    logic     fracHalf;  // exponent is exactly -1
  } ctrlStrobe_t;

endpackage

// File: rtl/fpToIntCtrl.sv
module fpToIntCtrl
  import fpToIntPkg::*;
#(
  parameter int EXP_W = 12,
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       inClass,
  input  logic [EXP_W-1:0] inExp,
  output logic             outValid,
  input  logic             outReady,
  output ctrlStrobe_t      strobe
);

  localparam logic signed [EXP_W-1:0] SAT_EXP  = EXP_W'(INT_W - 1);
  localparam logic signed [EXP_W-1:0] HALF_EXP = '1;  // -1

  logic signed [EXP_W-1:0] expS;
  logic                    acceptNow;
  pathSel_e                pathNext;

  assign expS      = $signed(inExp);
  assign inReady   = !outValid || outReady;
  assign acceptNow = inValid && inReady;

  always_comb begin
    unique case (opClass_e'(inClass))
      CLS_ZERO:         pathNext = PATH_ZERO;
      CLS_NAN, CLS_INF: pathNext = PATH_SAT;
      default: begin
        if (expS >= SAT_EXP)      pathNext = PATH_SAT;
        else if (expS[EXP_W-1])   pathNext = PATH_FRAC;
        else                      pathNext = PATH_SHIFT;
      end
    endcase
  end

  assign strobe.load     = acceptNow;
  assign strobe.path     = pathNext;
  assign strobe.fracHalf = (expS == HALF_EXP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else if (acceptNow) begin
      outValid <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/fpToIntDatapath.sv
module fpToIntDatapath
  import fpToIntPkg::*;
#(
  parameter int MANT_W = 56,
  parameter int INT_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic                      inSign,
  input  logic [$clog2(MANT_W)-1:0] expLow,
  input  logic [MANT_W-1:0]         inMant,
  input  logic [1:0]                inMode,
  output logic [INT_W-1:0]          outResult
);

  localparam int SH_W = $clog2(MANT_W);
  localparam logic [SH_W-1:0]  TOP_BIT = SH_W'(MANT_W - 1);
  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] ONE_VAL = INT_W'(1);
  localparam logic [INT_W-1:0] M1_VAL  = '1;

  logic [SH_W-1:0]   shAmt;
  logic [MANT_W-1:0] dataStage [0:SH_W];
  logic [MANT_W-1:0] keepStage [0:SH_W];
  logic [MANT_W-1:0] discMask;
  logic [MANT_W-1:0] halfMask;
  logic [INT_W-1:0]  intPart;
  logic [INT_W-1:0]  magRounded;
  logic [INT_W-1:0]  satVal;
  logic [INT_W-1:0]  shiftVal;
  logic [INT_W-1:0]  fracVal;
  logic [INT_W-1:0]  nextVal;
  logic              discNz;
  logic              halfSet;
  logic              incr;
  logic              unusedHi;

  // shift amount is the distance from the leading one to the binary point
  assign shAmt = TOP_BIT - expLow;

  assign dataStage[0] = inMant;
  assign keepStage[0] = '1;

  // one barrel stage per shift-amount bit; the mask walks with the data
  for (genvar i = 0; i < SH_W; i++) begin : gShift
    assign dataStage[i+1] = shAmt[i] ? (dataStage[i] >> (1 << i)) : dataStage[i];
    assign keepStage[i+1] = shAmt[i] ? (keepStage[i] << (1 << i)) : keepStage[i];
  end

  assign discMask = ~keepStage[SH_W];
  assign halfMask = discMask & ~(discMask >> 1);
  assign intPart  = dataStage[SH_W][INT_W-1:0];
  assign unusedHi = ^dataStage[SH_W][MANT_W-1:INT_W];

  assign discNz  = |(inMant & discMask);
  assign halfSet = |(inMant & halfMask);

  always_comb begin
    unique case (roundMode_e'(inMode))
      RM_NEAR: incr = halfSet;
      RM_ZERO: incr = 1'b0;
      RM_PINF: incr = discNz && !inSign;
      default: incr = discNz && inSign;
    endcase
  end

  assign magRounded = intPart + INT_W'(incr);
  assign satVal     = inSign ? NEG_MIN : POS_MAX;

  always_comb begin
    if (magRounded[INT_W-1]) shiftVal = satVal;
    else if (inSign)         shiftVal = -magRounded;
    else                     shiftVal = magRounded;
  end

  // magnitude below one: only the mode, sign and exponent -1 matter
  always_comb begin
    unique case (roundMode_e'(inMode))
      RM_NEAR: fracVal = strobe.fracHalf ? (inSign ? M1_VAL : ONE_VAL) : '0;
      RM_ZERO: fracVal = '0;
      RM_PINF: fracVal = inSign ? '0 : ONE_VAL;
      default: fracVal = inSign ? M1_VAL : '0;
    endcase
  end

  always_comb begin
    unique case (strobe.path)
      PATH_ZERO: nextVal = '0;
      PATH_SAT:  nextVal = satVal;
      PATH_FRAC: nextVal = fracVal;
      default:   nextVal = shiftVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outResult <= '0;
    end else if (strobe.load) begin
      outResult <= nextVal;
    end
  end

endmodule

// File: rtl/fpToIntTop.sv
module fpToIntTop
  import fpToIntPkg::*;
#(
  parameter int MANT_W = 56,
  parameter int EXP_W  = 12,
  parameter int INT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inClass,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [MANT_W-1:0] inMant,
  input  logic [1:0]        inMode,
  output logic              outValid,
  input  logic              outReady,
  output logic [INT_W-1:0]  outResult
);

  localparam int SH_W = $clog2(MANT_W);

  ctrlStrobe_t strobe;

  fpToIntCtrl #(
    .EXP_W(EXP_W),
    .INT_W(INT_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .inClass  (inClass),
    .inExp    (inExp),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  fpToIntDatapath #(
    .MANT_W(MANT_W),
    .INT_W (INT_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inSign    (inSign),
    .expLow    (inExp[SH_W-1:0]),
    .inMant    (inMant),
    .inMode    (inMode),
    .outResult (outResult)
  );

endmodule

// File: rtl/fpToIntChecker.sv
module fpToIntChecker #(
  parameter int MANT_W = 56,
  parameter int EXP_W  = 12,
  parameter int INT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [1:0]        inClass,
  input logic              inSign,
  input logic [EXP_W-1:0]  inExp,
  input logic [MANT_W-1:0] inMant,
  input logic [1:0]        inMode,
  input logic              outValid,
  input logic              outReady,
  input logic [INT_W-1:0]  outResult
);

  localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic signed [EXP_W-1:0] SAT_EXP = EXP_W'(INT_W - 1);
  localparam logic signed [EXP_W-1:0] M1_EXP  = '1;

  logic acc;
  logic isNorm;
  logic signed [EXP_W-1:0] expS;
  logic unusedMant;

  assign acc        = inValid && inReady;
  assign isNorm     = (inClass == 2'd0);
  assign expS       = $signed(inExp);
  assign unusedMant = ^inMant;

  AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    acc && inClass == 2'd1 |=> outValid && outResult == '0); // R1

  AST_SPECIAL_SAT: assert property (@(posedge clk) disable iff (!rstN)
    acc && inClass[1] |=> outResult == ($past(inSign) ? NEG_MIN : POS_MAX)); // R2

  AST_BIG_EXP_SAT: assert property (@(posedge clk) disable iff (!rstN)
    acc && isNorm && expS >= SAT_EXP |=> outResult == ($past(inSign) ? NEG_MIN : POS_MAX)); // R3

  AST_NEAR_TINY: assert property (@(posedge clk) disable iff (!rstN)
    acc && isNorm && expS < M1_EXP && inMode == 2'd0 |=> outResult == '0); // R4

  AST_TRUNC_FRAC: assert property (@(posedge clk) disable iff (!rstN)
    acc && isNorm && expS[EXP_W-1] && inMode == 2'd1 |=> outResult == '0); // R5

  AST_POS_NOT_NEG: assert property (@(posedge clk) disable iff (!rstN)
    acc && isNorm && !inSign |=> !outResult[INT_W-1]); // R9

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outResult)); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady); // R10

endmodule

bind fpToIntTop fpToIntChecker #(
  .MANT_W(MANT_W),
  .EXP_W (EXP_W),
  .INT_W (INT_W)
) uChecker (.*);

// File: tb/tb_fpToIntTop.sv
`timescale 1ns/1ps
module tb_fpToIntTop;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [1:0]  inClass;
  logic        inSign;
  logic [11:0] inExp;
  logic [55:0] inMant;
  logic [1:0]  inMode;
  logic        outValid;
  logic        outReady;
  logic [31:0] outResult;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fpToIntTop dut (.*);

  function automatic logic [31:0] satOf(input logic s);
    return s ? 32'h8000_0000 : 32'h7FFF_FFFF;
  endfunction

  // expected result, computed from the requirements
  function automatic logic [31:0] refConv(input logic [1:0] c, input logic s,
                                          input int e, input logic [55:0] m,
                                          input logic [1:0] md);
    logic [63:0] ip, disc, msk;
    logic        inc;
    int          sh;
    if (c == 2'd1) return 32'd0;                       // R1
    if (c[1]) return satOf(s);                         // R2
    if (e >= 31) return satOf(s);                      // R3
    if (e < 0) begin                                   // R4, R5
      case (md)
        2'd0: return (e < -1) ? 32'd0 : (s ? 32'hFFFF_FFFF : 32'd1);
        2'd1: return 32'd0;
        2'd2: return s ? 32'd0 : 32'd1;
        default: return s ? 32'hFFFF_FFFF : 32'd0;
      endcase
    end
    sh   = 55 - e;                                     // R6
    ip   = {8'd0, m} >> sh;
    msk  = (64'd1 << sh) - 64'd1;
    disc = {8'd0, m} & msk;
    case (md)
      2'd0: inc = m[sh-1];                             // R7
      2'd1: inc = 1'b0;
      2'd2: inc = (disc != 0) && !s;                   // R8
      default: inc = (disc != 0) && s;
    endcase
    ip = ip + 64'(inc);
    if (ip[31]) return satOf(s);                       // R9
    return s ? -ip[31:0] : ip[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic s, input int e,
                       input logic [55:0] m, input logic [1:0] md);
    inClass = c; inSign = s; inExp = 12'(e); inMant = m; inMode = md;
  endtask

  // one beat with outReady high; result sampled one cycle later at negedge
  task automatic conv(input string req, input logic [1:0] c, input logic s,
                      input int e, input logic [55:0] m, input logic [1:0] md);
    @(negedge clk);
    drive(c, s, e, m, md);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, {31'd0, outValid}, 32'd1);
    check(req, outResult, refConv(c, s, e, m, md));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [55:0] a, b;
    void'($urandom(32'd7717));
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b1;
    drive(2'd0, 1'b0, 0, 56'h80_0000_0000_0000, 2'd0);
    repeat (3) @(negedge clk);
    check("R11 outValid", {31'd0, outValid}, 32'd0);
    check("R11 outResult", outResult, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 ready idle", {31'd0, inReady}, 32'd1);

    // classes
    conv("R1 zero", 2'd1, 1'b1, 40, 56'h12_3456, 2'd2);
    conv("R2 nan neg", 2'd2, 1'b1, 0, 56'hC0_0000_0000_0000, 2'd0);
    conv("R2 nan pos", 2'd2, 1'b0, 0, 56'hC0_0000_0000_0000, 2'd1);
    conv("R2 inf neg", 2'd3, 1'b1, 0, 56'h0, 2'd3);
    conv("R2 inf pos", 2'd3, 1'b0, 0, 56'h0, 2'd2);
    conv("R3 exp31 neg", 2'd0, 1'b1, 31, 56'h80_0000_0000_0000, 2'd0);
    conv("R3 exp40 pos", 2'd0, 1'b0, 40, 56'hF0_0000_0000_0000, 2'd1);

    for (int md = 0; md < 4; md++) begin
      for (int s = 0; s < 2; s++) begin
        conv("R4 R5 half exp-1", 2'd0, 1'(s), -1, 56'h80_0000_0000_0000, 2'(md));
        conv("R4 R5 0.75", 2'd0, 1'(s), -1, 56'hC0_0000_0000_0000, 2'(md));
        conv("R4 R5 0.25", 2'd0, 1'(s), -2, 56'h80_0000_0000_0000, 2'(md));
        conv("R7 R8 2.5", 2'd0, 1'(s), 1, 56'hA0_0000_0000_0000, 2'(md));
        conv("R7 R8 1.5", 2'd0, 1'(s), 0, 56'hC0_0000_0000_0000, 2'(md));
        conv("R6 exact 3", 2'd0, 1'(s), 1, 56'hC0_0000_0000_0000, 2'(md));
        conv("R8 just above 2", 2'd0, 1'(s), 1, 56'h80_0000_0000_0001, 2'(md));
        conv("R7 just below 3", 2'd0, 1'(s), 1, 56'hBF_FFFF_FFFF_FFFF, 2'(md));
        conv("R9 near 2^31", 2'd0, 1'(s), 30, 56'hFF_FFFF_FFFF_FFFF, 2'(md));
        conv("R9 2^31-1 exact", 2'd0, 1'(s), 30, 56'hFF_FFFF_FE00_0000, 2'(md));
        conv("R6 one", 2'd0, 1'(s), 0, 56'h80_0000_0000_0000, 2'(md));
      end
    end

    // random sweep over exponents -3..33
    for (int n = 0; n < 3000; n++) begin
      logic [55:0] m;
      int e;
      m = {1'b1, 55'({$urandom, $urandom})};
      if ($urandom_range(2) == 0)
        m = m & ~((56'd1 << $urandom_range(54)) - 56'd1);
      e = int'($urandom_range(36)) - 3;
      conv("R6 R7 R8 R9 random", 2'd0, 1'($urandom_range(1)), e, m, 2'($urandom_range(3)));
    end

    // stall: result held, ready low, next beat waits
    a = 56'hA0_0000_0000_0000;
    b = 56'hE0_0000_0000_0000;
    @(negedge clk);
    outReady = 1'b0;
    drive(2'd0, 1'b1, 1, a, 2'd0);
    inValid = 1'b1;
    @(negedge clk);
    drive(2'd0, 1'b0, 2, b, 2'd1);
    check("R10 stall valid", {31'd0, outValid}, 32'd1);
    check("R10 stall ready", {31'd0, inReady}, 32'd0);
    check("R10 first result", outResult, refConv(2'd0, 1'b1, 1, a, 2'd0));
    repeat (2) @(negedge clk);
    check("R10 held", outResult, refConv(2'd0, 1'b1, 1, a, 2'd0));
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R10 second result", outResult, refConv(2'd0, 1'b0, 2, b, 2'd1));
    @(negedge clk);
    check("R10 drained", {31'd0, outValid}, 32'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule